// File: doc/BRIEF.md
# Associative TLB Translation Unit

This block is a fully associative translation buffer. Every cycle it compares the presented virtual address against all stored entries. Each entry has its own page size, an optional process tag and a zone number. From the winning entry it forms the physical address and the read, write and execute rights. It also reports whether the requested kind of access is allowed. The result appears on registered outputs one clock after the inputs are applied.

Entries are written through a simple load port: an index, a tag word, a data word and a translation ID, all taken in one cycle. Software-visible register decoding, fault raising and table walking are left to neighbouring logic. Those neighbours use the hit flag and the rights outputs to decide what to do.

Top module: `assoc_tlb`

## Requirements
- R1: While reset is asserted and after it is released, all outputs are zero and every entry is invalid, so lookups miss until entries are loaded.
- R2: When `ldEn` is high at a rising edge, the tag word, data word and translation ID are stored at `ldIdx`, and lookups see the new contents from the next cycle on.
- R3: Tag bits 9:7 hold a size code c that selects a page of 2^(10+2c) bytes (1 KB up to 16 MB). An entry matches when the virtual address and tag bits 31:(10+2c) are equal.
- R4: Only an entry whose tag bit 6 (valid) is set can match.
- R5: An entry with a translation ID of zero matches any process. A nonzero ID matches only when it equals `procId`.
- R6: When several entries match, the lowest index wins, and that index is reported on `idxQ`.
- R7: On a hit, the physical address takes data bits 31:(10+2c) from the entry and the low 10+2c bits from the virtual address.
- R8: Without a zone override, a hit grants read, grants write only if data bit 8 is set, and grants execute only if data bit 9 is set.
- R9: Data bits 7:4 pick zone z, and the zone code is `zoneProt[31-2z:30-2z]`. Code 00 gives user mode no rights and supervisor the page bits. Code 01 gives the page bits in both modes. Code 10 gives user the page bits and supervisor full rights. Code 11 gives full rights in both modes.
- R10: `accOkQ` reflects the right that matches `accKind`: 0 is read, 1 is write, 2 is fetch. Kind 3 is never allowed.
- R11: Outputs change only at the rising edge after the inputs change. A miss drives index, address and all rights to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldEn | input | 1 | Load an entry this cycle |
| ldIdx | input | 6 | Entry index to load |
| ldTag | input | 32 | Tag word: page number, size code 9:7, valid bit 6 |
| ldData | input | 32 | Data word: real page number, execute bit 9, write bit 8, zone 7:4 |
| ldTid | input | 8 | Translation ID of the loaded entry |
| vaddr | input | 32 | Virtual address to translate |
| accKind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| userMode | input | 1 | 1 for user mode, 0 for supervisor |
| procId | input | 8 | Current process ID (low bits) |
| zoneProt | input | 32 | Zone protection word, 2 bits per zone, zone 0 at the top |
| hitQ | output | 1 | Registered hit flag |
| idxQ | output | 6 | Registered index of the winning entry |
| paddrQ | output | 32 | Registered physical address |
| rdOkQ | output | 1 | Read right |
| wrOkQ | output | 1 | Write right |
| exOkQ | output | 1 | Execute right |
| accOkQ | output | 1 | Requested access kind is allowed |

## Verification
The assertions assume three things about the inputs. First, `ldEn` is held low during reset, or a load made in a reset cycle is simply lost. Second, `ldIdx` stays within the entry count. Third, the lookup inputs settle before each rising edge. The bench changes every input on the falling edge, keeps indices below 64 and releases reset before any load. It compares each registered result with its own model of the entry table, written from the stated bit positions, one cycle after the stimulus.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int WORD_W   = 32;
  localparam int SIZE_LSB = 7;
  localparam int VALID_BIT = 6;
  localparam int WE_BIT   = 8;
  localparam int EX_BIT   = 9;
  localparam int ZONE_LSB = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_t;

  typedef enum logic [1:0] {
    ZN_USER_NONE = 2'b00,
    ZN_PAGE      = 2'b01,
    ZN_SUP_FULL  = 2'b10,
    ZN_ALL_FULL  = 2'b11
  } zoneCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic allowRd;
    logic allowWr;
    logic allowEx;
    logic allowAcc;
  } tlbStrobes_t;

  // keep-mask for a page: ones above the page offset
  function automatic logic [WORD_W-1:0] sizeMask(input logic [2:0] code);
    logic [4:0] sh;
    sh = 5'd10 + {1'b0, code, 1'b0};
    return {WORD_W{1'b1}} << sh;
  endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               load,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [WORD_W-1:0]  wrTag,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [TID_W-1:0]   wrTid,
  input  logic [WORD_W-1:0]  vaddr,
  input  logic [TID_W-1:0]   pidLow,
  input  logic [IDX_W-1:0]   selIdx,
  output logic [ENTRIES-1:0] matchVec,
  output logic [WORD_W-1:0]  selData,
  output logic [WORD_W-1:0]  selMask
);
  logic [WORD_W-1:0] dataArr [ENTRIES];
  logic [WORD_W-1:0] maskArr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              validQ;
    logic [WORD_W-1:0] tagQ;
    logic [WORD_W-1:0] dataQ;
    logic [TID_W-1:0]  tidQ;
    logic              wrHere;
    logic [WORD_W-1:0] pageMask;
    logic              pidOk;

    assign wrHere = load && (wrIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN)       validQ <= 1'b0;
      else if (wrHere) validQ <= wrTag[VALID_BIT];
    end

    always_ff @(posedge clk) begin
      if (wrHere) begin
        tagQ  <= wrTag;
        dataQ <= wrData;
        tidQ  <= wrTid;
      end
    end

    assign pageMask    = sizeMask(tagQ[SIZE_LSB +: 3]);
    assign pidOk       = (tidQ == '0) || (tidQ == pidLow);
    assign matchVec[g] = validQ && pidOk && (((vaddr ^ tagQ) & pageMask) == '0);
    assign dataArr[g]  = dataQ;
    assign maskArr[g]  = pageMask;

    // R2 / R4: a load leaves the entry's valid state equal to the loaded bit
    p_load_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(wrHere)) |-> (validQ == $past(wrTag[VALID_BIT])));
  end

  assign selData = dataArr[selIdx];
  assign selMask = maskArr[selIdx];
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] reqVec,
  output logic               anyHit,
  output logic [IDX_W-1:0]   firstIdx
);
  always_comb begin
    firstIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (reqVec[i]) firstIdx = IDX_W'(i);
    end
  end
  assign anyHit = |reqVec;
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobes_t       strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrTag,
  input  logic [WORD_W-1:0] wrData,
  input  logic [TID_W-1:0]  wrTid,
  input  logic [WORD_W-1:0] vaddr,
  input  logic [TID_W-1:0]  pidLow,
  output logic              hitC,
  output logic [3:0]        selZone,
  output logic              selWe,
  output logic              selEx,
  output logic              hitQ,
  output logic [IDX_W-1:0]  idxQ,
  output logic [WORD_W-1:0] paddrQ,
  output logic              rdQ,
  output logic              wrQ,
  output logic              exQ,
  output logic              okQ
);
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]   selIdx;
  logic [WORD_W-1:0]  selData;
  logic [WORD_W-1:0]  selMask;
  logic [WORD_W-1:0]  paddrC;
  logic [ENTRIES-1:0] belowWin;

  tlb_entry_array #(.ENTRIES(ENTRIES), .TID_W(TID_W)) uArray (
    .clk(clk), .rstN(rstN), .load(strb.load), .wrIdx(wrIdx),
    .wrTag(wrTag), .wrData(wrData), .wrTid(wrTid),
    .vaddr(vaddr), .pidLow(pidLow), .selIdx(selIdx),
    .matchVec(matchVec), .selData(selData), .selMask(selMask)
  );

  tlb_prio_enc #(.ENTRIES(ENTRIES)) uPrio (
    .reqVec(matchVec), .anyHit(hitC), .firstIdx(selIdx)
  );

  assign selZone = selData[ZONE_LSB +: 4];
  assign selWe   = selData[WE_BIT];
  assign selEx   = selData[EX_BIT];
  assign paddrC  = (selData & selMask) | (vaddr & ~selMask);
  assign belowWin = (ENTRIES'(1) << selIdx) - ENTRIES'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ   <= 1'b0;
      idxQ   <= '0;
      paddrQ <= '0;
      rdQ    <= 1'b0;
      wrQ    <= 1'b0;
      exQ    <= 1'b0;
      okQ    <= 1'b0;
    end else begin
      hitQ   <= hitC;
      idxQ   <= hitC ? selIdx : '0;
      paddrQ <= hitC ? paddrC : '0;
      rdQ    <= hitC && strb.allowRd;
      wrQ    <= hitC && strb.allowWr;
      exQ    <= hitC && strb.allowEx;
      okQ    <= hitC && strb.allowAcc;
    end
  end

  // R6: the chosen entry is a matching one and none below it matches
  p_win_matches_r6: assert property (@(posedge clk) disable iff (!rstN)
    hitC |-> matchVec[selIdx]);
  p_win_lowest_r6: assert property (@(posedge clk) disable iff (!rstN)
    hitC |-> ((matchVec & belowWin) == '0));
  // R11: a miss leaves index, address and rights at zero
  p_miss_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !hitQ |-> (idxQ == '0 && paddrQ == '0 && !rdQ && !wrQ && !exQ && !okQ));
  // R8 / R9: no zone code grants write or execute while withholding read
  p_rd_covers_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrQ || exQ) |-> rdQ);
  // R10: an allowed access needs a hit
  p_ok_needs_hit_r10: assert property (@(posedge clk) disable iff (!rstN)
    okQ |-> hitQ);
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic              ldEn,
  input  logic [WORD_W-1:0] zoneProt,
  input  logic              userMode,
  input  logic [1:0]        accKind,
  input  logic [3:0]        selZone,
  input  logic              selWe,
  input  logic              selEx,
  output tlbStrobes_t       strb
);
  zoneCode_t zc;
  logic rd, wr, ex;

  assign zc = zoneCode_t'(zoneProt[(31 - 2 * int'(selZone)) -: 2]);

  always_comb begin
    rd = 1'b1;
    wr = selWe;
    ex = selEx;
    unique case (zc)
      ZN_USER_NONE: if (userMode) begin rd = 1'b0; wr = 1'b0; ex = 1'b0; end
      ZN_PAGE:      ;
      ZN_SUP_FULL:  if (!userMode) begin wr = 1'b1; ex = 1'b1; end
      ZN_ALL_FULL:  begin wr = 1'b1; ex = 1'b1; end
      default:      ;
    endcase
  end

  always_comb begin
    strb.load    = ldEn;
    strb.allowRd = rd;
    strb.allowWr = wr;
    strb.allowEx = ex;
    unique case (accKind_t'(accKind))
      ACC_READ:  strb.allowAcc = rd;
      ACC_WRITE: strb.allowAcc = wr;
      ACC_FETCH: strb.allowAcc = ex;
      default:   strb.allowAcc = 1'b0;
    endcase
  end
endmodule

// File: rtl/assoc_tlb.sv
module assoc_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldEn,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic [WORD_W-1:0] ldTag,
  input  logic [WORD_W-1:0] ldData,
  input  logic [TID_W-1:0]  ldTid,
  input  logic [WORD_W-1:0] vaddr,
  input  logic [1:0]        accKind,
  input  logic              userMode,
  input  logic [TID_W-1:0]  procId,
  input  logic [WORD_W-1:0] zoneProt,
  output logic              hitQ,
  output logic [IDX_W-1:0]  idxQ,
  output logic [WORD_W-1:0] paddrQ,
  output logic              rdOkQ,
  output logic              wrOkQ,
  output logic              exOkQ,
  output logic              accOkQ
);
  tlbStrobes_t strb;
  logic       hitC;
  logic [3:0] selZone;
  logic       selWe;
  logic       selEx;

  tlb_ctrl uCtrl (
    .ldEn(ldEn), .zoneProt(zoneProt), .userMode(userMode), .accKind(accKind),
    .selZone(selZone), .selWe(selWe), .selEx(selEx), .strb(strb)
  );

  tlb_datapath #(.ENTRIES(ENTRIES), .TID_W(TID_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrIdx(ldIdx), .wrTag(ldTag), .wrData(ldData), .wrTid(ldTid),
    .vaddr(vaddr), .pidLow(procId),
    .hitC(hitC), .selZone(selZone), .selWe(selWe), .selEx(selEx),
    .hitQ(hitQ), .idxQ(idxQ), .paddrQ(paddrQ),
    .rdQ(rdOkQ), .wrQ(wrOkQ), .exQ(exOkQ), .okQ(accOkQ)
  );

  // R1: the cycle after reset every registered output is cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!hitQ && idxQ == '0 && paddrQ == '0 && !rdOkQ && !accOkQ));
endmodule

// File: tb/assoc_tlb_test.sv
module assoc_tlb_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldEn = 1'b0;
  logic [5:0]  ldIdx = '0;
  logic [31:0] ldTag = '0, ldData = '0;
  logic [7:0]  ldTid = '0;
  logic [31:0] vaddr = '0;
  logic [1:0]  accKind = '0;
  logic        userMode = 1'b0;
  logic [7:0]  procId = '0;
  logic [31:0] zoneProt = '0;
  logic        hitQ, rdOkQ, wrOkQ, exOkQ, accOkQ;
  logic [5:0]  idxQ;
  logic [31:0] paddrQ;

  int total = 0;
  int bad = 0;
  logic [31:0] shTag [64];
  logic [31:0] shData [64];
  logic [7:0]  shTid [64];

  always #2 clk = ~clk;

  assoc_tlb uut (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .ldIdx(ldIdx), .ldTag(ldTag),
    .ldData(ldData), .ldTid(ldTid), .vaddr(vaddr), .accKind(accKind),
    .userMode(userMode), .procId(procId), .zoneProt(zoneProt),
    .hitQ(hitQ), .idxQ(idxQ), .paddrQ(paddrQ), .rdOkQ(rdOkQ),
    .wrOkQ(wrOkQ), .exOkQ(exOkQ), .accOkQ(accOkQ)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // model of the table built from the stated field positions
  task automatic refLookup(input logic [31:0] va, input logic [1:0] kind, input logic usr,
                           input logic [7:0] pid, input logic [31:0] zp,
                           output logic h, output logic [5:0] ix, output logic [31:0] pa,
                           output logic r, output logic w, output logic x, output logic ok);
    logic [31:0] m;
    logic [3:0]  z;
    logic [1:0]  zc;
    h = 0; ix = 0; pa = 0; r = 0; w = 0; x = 0; ok = 0;
    for (int i = 63; i >= 0; i--) begin
      m = 32'hFFFF_FFFF << (10 + 2 * int'(shTag[i][9:7]));
      if (shTag[i][6] && ((va & m) == (shTag[i] & m)) && (shTid[i] == 0 || shTid[i] == pid)) begin
        h = 1; ix = 6'(i); pa = (shData[i] & m) | (va & ~m);
      end
    end
    if (h) begin
      z  = shData[ix][7:4];
      zc = zp[31 - 2 * int'(z) -: 2];
      r = 1; w = shData[ix][8]; x = shData[ix][9];
      if (zc == 2'b00 && usr) begin r = 0; w = 0; x = 0; end
      if ((zc == 2'b10 && !usr) || zc == 2'b11) begin w = 1; x = 1; end
      ok = (kind == 0) ? r : (kind == 1) ? w : (kind == 2) ? x : 1'b0;
    end
  endtask

  task automatic loadEntry(input int idx, input logic [31:0] epn, input logic [2:0] code,
                           input logic vld, input logic [31:0] rpn, input logic [3:0] zone,
                           input logic we, input logic ex, input logic [7:0] tid);
    @(negedge clk);
    ldEn  = 1'b1;
    ldIdx = 6'(idx);
    ldTag = (epn & ~32'h3FF) | (32'(code) << 7) | (32'(vld) << 6);
    ldData = (rpn & ~32'h3FF) | (32'(ex) << 9) | (32'(we) << 8) | (32'(zone) << 4);
    ldTid = tid;
    shTag[idx] = ldTag; shData[idx] = ldData; shTid[idx] = tid;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic look(input string req, input logic [31:0] va, input logic [1:0] kind,
                      input logic usr, input logic [7:0] pid, input logic [31:0] zp);
    logic h, r, w, x, ok;
    logic [5:0] ix;
    logic [31:0] pa;
    @(negedge clk);
    vaddr = va; accKind = kind; userMode = usr; procId = pid; zoneProt = zp;
    refLookup(va, kind, usr, pid, zp, h, ix, pa, r, w, x, ok);
    @(posedge clk);
    @(negedge clk);
    chk(req, "hit", 32'(hitQ), 32'(h));
    chk(req, "idx", 32'(idxQ), 32'(ix));
    chk(req, "paddr", paddrQ, pa);
    chk(req, "rd", 32'(rdOkQ), 32'(r));
    chk(req, "wr", 32'(wrOkQ), 32'(w));
    chk(req, "ex", 32'(exOkQ), 32'(x));
    chk(req, "acc", 32'(accOkQ), 32'(ok));
  endtask

  task automatic testReset;
    chk("R1", "hit in reset", 32'(hitQ), 0);
    chk("R1", "paddr in reset", paddrQ, 0);
    @(negedge clk) rstN = 1'b1;
    look("R1", 32'h0000_0000, 2'd0, 1'b0, 8'd0, 32'hFFFF_FFFF);
    chk("R1", "miss after reset", 32'(hitQ), 0);
  endtask

  task automatic testBasic;
    // 4 KB page, zone 1 coded 01
    loadEntry(5, 32'h1234_5000, 3'd1, 1'b1, 32'hABCD_E000, 4'd1, 1'b1, 1'b0, 8'd0);
    look("R2", 32'h1234_5678, 2'd1, 1'b0, 8'd7, 32'h1000_0000);
    chk("R7", "paddr 4K", paddrQ, 32'hABCD_E678);
    chk("R2", "idx", 32'(idxQ), 5);
    look("R10", 32'h1234_5678, 2'd2, 1'b0, 8'd7, 32'h1000_0000);
    chk("R10", "fetch denied", 32'(accOkQ), 0);
    look("R10", 32'h1234_5678, 2'd3, 1'b0, 8'd7, 32'h1000_0000);
    chk("R10", "kind 3 denied", 32'(accOkQ), 0);
    look("R3", 32'h1234_6000, 2'd0, 1'b0, 8'd7, 32'h1000_0000);
    chk("R3", "next 4K page misses", 32'(hitQ), 0);
  endtask

  task automatic testSizes;
    loadEntry(10, 32'h4000_0000, 3'd7, 1'b1, 32'h8000_0000, 4'd0, 1'b0, 1'b1, 8'd0);
    loadEntry(11, 32'h7000_0400, 3'd0, 1'b1, 32'h0000_5C00, 4'd0, 1'b1, 1'b1, 8'd0);
    look("R3", 32'h40FE_DCBA, 2'd2, 1'b1, 8'd0, 32'h4000_0000);
    chk("R7", "paddr 16M", paddrQ, 32'h80FE_DCBA);
    look("R3", 32'h7000_07FF, 2'd0, 1'b1, 8'd0, 32'h4000_0000);
    chk("R7", "paddr 1K", paddrQ, 32'h0000_5FFF);
    look("R3", 32'h7000_0800, 2'd0, 1'b1, 8'd0, 32'h4000_0000);
    for (int c = 2; c < 7; c++) begin
      loadEntry(12, 32'h2000_0000, 3'(c), 1'b1, 32'h0100_0000, 4'd0, 1'b0, 1'b0, 8'd0);
      look("R3", 32'h2000_0000 | ((32'd1 << (10 + 2 * c)) - 1), 2'd0, 1'b0, 8'd0, 32'h4000_0000);
      look("R3", 32'h2000_0000 | (32'd1 << (10 + 2 * c)), 2'd0, 1'b0, 8'd0, 32'h4000_0000);
    end
  endtask

  task automatic testValid;
    loadEntry(5, 32'h1234_5000, 3'd1, 1'b0, 32'hABCD_E000, 4'd1, 1'b1, 1'b0, 8'd0);
    look("R4", 32'h1234_5678, 2'd0, 1'b0, 8'd0, 32'h1000_0000);
    chk("R4", "cleared valid misses", 32'(hitQ), 0);
  endtask

  task automatic testTid;
    loadEntry(20, 32'h0300_0000, 3'd2, 1'b1, 32'h0900_0000, 4'd0, 1'b1, 1'b1, 8'h33);
    look("R5", 32'h0300_1234, 2'd0, 1'b0, 8'h33, 32'h4000_0000);
    chk("R5", "tid match hits", 32'(hitQ), 1);
    look("R5", 32'h0300_1234, 2'd0, 1'b0, 8'h34, 32'h4000_0000);
    chk("R5", "tid mismatch misses", 32'(hitQ), 0);
  endtask

  task automatic testPriority;
    loadEntry(40, 32'h0500_0000, 3'd5, 1'b1, 32'h0A00_0000, 4'd0, 1'b0, 1'b0, 8'd0);
    loadEntry(30, 32'h0500_0000, 3'd1, 1'b1, 32'h0B00_0000, 4'd0, 1'b1, 1'b0, 8'd0);
    look("R6", 32'h0500_0ABC, 2'd0, 1'b0, 8'd0, 32'h4000_0000);
    chk("R6", "lowest wins", 32'(idxQ), 30);
    loadEntry(30, 32'h0500_0000, 3'd1, 1'b0, 32'h0B00_0000, 4'd0, 1'b1, 1'b0, 8'd0);
    look("R6", 32'h0500_0ABC, 2'd0, 1'b0, 8'd0, 32'h4000_0000);
    chk("R6", "next index wins", 32'(idxQ), 40);
  endtask

  task automatic testZones;
    loadEntry(50, 32'h0600_0000, 3'd1, 1'b1, 32'h0C00_0000, 4'd3, 1'b0, 1'b0, 8'd0);
    for (int c = 0; c < 4; c++) begin
      for (int u = 0; u < 2; u++) begin
        look("R9", 32'h0600_0010, 2'd1, 1'(u), 8'd0, 32'(c) << 24);
        look("R8", 32'h0600_0010, 2'd0, 1'(u), 8'd0, 32'(c) << 24);
      end
    end
    look("R9", 32'h0600_0010, 2'd0, 1'b1, 8'd0, 32'h0000_0000);
    chk("R9", "code 00 user read", 32'(rdOkQ), 0);
    look("R9", 32'h0600_0010, 2'd1, 1'b0, 8'd0, 32'h0200_0000);
    chk("R9", "code 10 super write", 32'(wrOkQ), 1);
    look("R8", 32'h0600_0010, 2'd1, 1'b0, 8'd0, 32'h0100_0000);
    chk("R8", "page write bit clear", 32'(wrOkQ), 0);
  endtask

  task automatic testLatency;
    look("R11", 32'hFFFF_0000, 2'd0, 1'b0, 8'd0, 32'h4000_0000);
    @(negedge clk);
    vaddr = 32'h0600_0020; userMode = 1'b0; zoneProt = 32'h4000_0000; accKind = 2'd0;
    #1;
    chk("R11", "held before edge", 32'(hitQ), 0);
    @(posedge clk); #1;
    chk("R11", "updated after edge", 32'(hitQ), 1);
    chk("R11", "index after edge", 32'(idxQ), 50);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      shTag[i] = '0; shData[i] = '0; shTid[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    testReset();
    testBasic();
    testSizes();
    testValid();
    testTid();
    testPriority();
    testZones();
    testLatency();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule